// File: doc/BRIEF.md
# Multi-vector predicated byte store sequencer

This block turns one already-decoded store of byte elements from two or four consecutive vector registers into a stream of single-byte memory write requests. On a start pulse it captures a 64-bit base address, a flag telling whether that base is the stack pointer, a signed 4-bit vector offset, a register-count select, a lane mask covering every byte of every register, and the register contents laid side by side. It then walks every lane of the selected registers in ascending order. For each active lane it presents one write request on a valid/ready channel. When the walk is finished it pulses done.

The offset counts whole groups of registers. It is scaled by the register count and by the number of bytes per register before it is added to the base, and all address arithmetic wraps modulo 2^64. An inactive lane produces no request and still costs one cycle. The number of cycles from start to done therefore depends on the register count and on back-pressure only, never on the data. When the base is the stack pointer, an alignment-check pulse is raised. A parameter selects whether that pulse is also raised when no lane is active.

Top module: `mvst_seq`

## Requirements
- R1: After a synchronous reset, busy, done, req_valid and sp_align_chk are all low.
- R2: The request for lane L has address base + sext(vec_off) × (nregs × ELEMS) + L, modulo 2^64. nregs is 4 when four_regs is 1 and 2 when it is 0. Lane L = r × ELEMS + e is element e of register r.
- R3: The request for lane L carries store_data[8L+7:8L] as captured at start.
- R4: A lane whose lane_mask bit is 0 produces no request. Requests are issued in strictly ascending lane order.
- R5: With four_regs = 0, only lanes 0 to 2×ELEMS−1 are walked. Mask and data bits above them have no effect on requests or on the alignment pulse.
- R6: Every request has req_tag_chk equal to the inverse of the captured base_is_sp, with req_is_store = 1, req_contig = 1 and req_nontemp = 0.
- R7: When start is accepted with base_is_sp = 1 and at least one walked lane active, sp_align_chk is high for exactly the one cycle following the accepting edge. It never rises for a non-stack-pointer base.
- R8: When start is accepted with base_is_sp = 1 and no walked lane active, sp_align_chk pulses if and only if parameter SP_CHK_EMPTY is 1.
- R9: While req_valid is high and req_ready is low, req_valid, req_addr and req_byte hold their values.
- R10: With req_ready held high, done is a single-cycle pulse that appears nregs × ELEMS + 1 cycles after the accepting edge, whatever the data or mask. busy is high from the accepting edge until done rises, and req_valid is low whenever busy is low.
- R11: A start asserted while busy is ignored. The running walk keeps its captured operands and produces exactly one done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a store; accepted only while idle |
| base_addr | input | 64 | Base byte address |
| base_is_sp | input | 1 | Base comes from the stack pointer |
| vec_off | input | 4 | Signed offset in units of whole register groups |
| four_regs | input | 1 | 1 selects four registers, 0 selects two |
| lane_mask | input | 4×ELEMS | Active flag per byte lane |
| store_data | input | 32×ELEMS | Register bytes, lane L at bits 8L+7:8L |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_align_chk | output | 1 | Stack-pointer alignment check pulse |
| req_valid | output | 1 | Write request valid |
| req_ready | input | 1 | Write request accepted |
| req_addr | output | 64 | Request byte address |
| req_byte | output | 8 | Request data byte |
| req_tag_chk | output | 1 | Request is tag-checked |
| req_is_store | output | 1 | Request is a store |
| req_contig | output | 1 | Contiguous attribute |
| req_nontemp | output | 1 | Non-temporal attribute |

## Verification
The walk reaching its last lane can coincide with back-pressure on the request slot. When it does, the final request must stay frozen and the drain must hold off done until that request is taken. This is provoked by driving req_ready from a pseudo-random pattern while the mask activates the top lane. It is judged by the per-cycle stability check and by requiring the full, ordered request list to have arrived before done is seen. A second overlap, a start pulse during a walk, is provoked mid-run with a different base and judged by the addresses and the single done that follow.

// File: rtl/mvst_pkg.sv
package mvst_pkg;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_RUN   = 2'd1,
    WS_DRAIN = 2'd2
  } walk_st_t;

  typedef struct packed {
    logic [63:0] addr;
    logic [7:0]  data;
    logic        tag_chk;
  } wr_req_t;

  localparam logic ATTR_STORE   = 1'b1;
  localparam logic ATTR_CONTIG  = 1'b1;
  localparam logic ATTR_NONTEMP = 1'b0;

  function automatic logic [63:0] sext4(input logic [3:0] v);
    return {{60{v[3]}}, v};
  endfunction

endpackage

// File: rtl/mvst_addr_gen.sv
module mvst_addr_gen #(
  parameter int ELEMS = 16
) (
  input  logic [63:0] base,
  input  logic [3:0]  off,
  input  logic        four,
  output logic [63:0] first_addr
);
  import mvst_pkg::*;

  localparam int  SPAN2 = 2 * ELEMS;
  localparam int  SPAN4 = 4 * ELEMS;
  localparam bit  POW2  = ((ELEMS & (ELEMS - 1)) == 0);
  localparam int  SH2   = $clog2(SPAN2);
  localparam int  SH4   = $clog2(SPAN4);

  logic [63:0] off_x;
  logic [63:0] scaled;

  assign off_x = sext4(off);

  generate
    if (POW2) begin : g_shift
      assign scaled = four ? (off_x << SH4) : (off_x << SH2);
    end else begin : g_mul
      logic [63:0] span;
      assign span   = four ? 64'(SPAN4) : 64'(SPAN2);
      assign scaled = off_x * span;
    end
  endgenerate

  assign first_addr = base + scaled;

endmodule

// File: rtl/mvst_lane_walker.sv
module mvst_lane_walker #(
  parameter int LANES = 64,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             four,
  input  logic             slot_free,
  output logic [IDX_W-1:0] idx,
  output logic             step,
  output logic             advance,
  output logic             busy,
  output logic             done
);
  import mvst_pkg::*;

  localparam logic [IDX_W-1:0] LAST4 = IDX_W'(LANES - 1);
  localparam logic [IDX_W-1:0] LAST2 = IDX_W'(LANES / 2 - 1);

  walk_st_t         st;
  logic [IDX_W-1:0] last;

  assign last    = four ? LAST4 : LAST2;
  assign busy    = (st != WS_IDLE);
  assign advance = busy && slot_free;
  assign step    = (st == WS_RUN) && slot_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= WS_IDLE;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        WS_IDLE: begin
          if (launch) begin
            st  <= WS_RUN;
            idx <= '0;
          end
        end
        WS_RUN: begin
          if (slot_free) begin
            if (idx == last) begin
              st <= WS_DRAIN;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        WS_DRAIN: begin
          if (slot_free) begin
            st   <= WS_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= WS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mvst_req_slot.sv
module mvst_req_slot (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              fill,
  input  mvst_pkg::wr_req_t nxt,
  output logic              valid,
  output mvst_pkg::wr_req_t cur
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
    end else if (advance) begin
      valid <= fill;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
    end else if (advance && fill) begin
      cur <= nxt;
    end
  end

endmodule

// File: rtl/mvst_seq.sv
module mvst_seq #(
  parameter int ELEMS        = 16,
  parameter bit SP_CHK_EMPTY = 1'b1,
  localparam int MAX_REGS = 4,
  localparam int LANES    = MAX_REGS * ELEMS,
  localparam int HALF     = LANES / 2,
  localparam int IDX_W    = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [63:0]        base_addr,
  input  logic               base_is_sp,
  input  logic [3:0]         vec_off,
  input  logic               four_regs,
  input  logic [LANES-1:0]   lane_mask,
  input  logic [LANES*8-1:0] store_data,
  output logic               busy,
  output logic               done,
  output logic               sp_align_chk,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [63:0]        req_addr,
  output logic [7:0]         req_byte,
  output logic               req_tag_chk,
  output logic               req_is_store,
  output logic               req_contig,
  output logic               req_nontemp
);
  import mvst_pkg::*;

  logic               accept;
  logic [63:0]        first_addr;
  logic [63:0]        addr_q;
  logic               sp_q;
  logic               four_q;
  logic [LANES-1:0]   mask_q;
  logic [LANES*8-1:0] data_q;
  logic               any_active;
  logic               slot_free;
  logic [IDX_W-1:0]   idx;
  logic               step;
  logic               advance;
  logic               fill;
  wr_req_t            nxt_req;
  wr_req_t            cur_req;

  assign accept    = start && !busy;
  assign slot_free = !req_valid || req_ready;

  mvst_addr_gen #(.ELEMS(ELEMS)) addr_i (
    .base       (base_addr),
    .off        (vec_off),
    .four       (four_regs),
    .first_addr (first_addr)
  );

  // Operand capture: control state with reset, bulk data without.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      sp_q   <= 1'b0;
      four_q <= 1'b0;
      mask_q <= '0;
    end else if (accept) begin
      addr_q <= first_addr;
      sp_q   <= base_is_sp;
      four_q <= four_regs;
      mask_q <= lane_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      data_q <= store_data;
    end
  end

  // Only lanes of the selected registers count as active.
  generate
    if (LANES > 1) begin : g_any
      assign any_active = four_regs ? (|lane_mask) : (|lane_mask[HALF-1:0]);
    end else begin : g_any1
      assign any_active = |lane_mask;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_align_chk <= 1'b0;
    end else begin
      sp_align_chk <= accept && base_is_sp && (any_active || SP_CHK_EMPTY);
    end
  end

  mvst_lane_walker #(.LANES(LANES)) walk_i (
    .clk       (clk),
    .rst       (rst),
    .launch    (accept),
    .four      (four_q),
    .slot_free (slot_free),
    .idx       (idx),
    .step      (step),
    .advance   (advance),
    .busy      (busy),
    .done      (done)
  );

  assign fill            = step && mask_q[idx];
  assign nxt_req.addr    = addr_q + {{(64-IDX_W){1'b0}}, idx};
  assign nxt_req.data    = data_q[{idx, 3'b000} +: 8];
  assign nxt_req.tag_chk = !sp_q;

  mvst_req_slot slot_i (
    .clk     (clk),
    .rst     (rst),
    .advance (advance),
    .fill    (fill),
    .nxt     (nxt_req),
    .valid   (req_valid),
    .cur     (cur_req)
  );

  assign req_addr     = cur_req.addr;
  assign req_byte     = cur_req.data;
  assign req_tag_chk  = cur_req.tag_chk;
  assign req_is_store = ATTR_STORE;
  assign req_contig   = ATTR_CONTIG;
  assign req_nontemp  = ATTR_NONTEMP;

endmodule

// File: rtl/mvst_seq_chk.sv
module mvst_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        base_is_sp,
  input logic        busy,
  input logic        done,
  input logic        sp_align_chk,
  input logic        req_valid,
  input logic        req_ready,
  input logic [63:0] req_addr,
  input logic [7:0]  req_byte,
  input logic        req_tag_chk,
  input logic        req_is_store,
  input logic        req_contig,
  input logic        req_nontemp
);

  logic sp_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_seen <= 1'b0;
    end else if (start && !busy) begin
      sp_seen <= base_is_sp;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_byte))); // R9

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !req_valid); // R10

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R10

  AST_TAG_FOLLOWS_BASE: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_tag_chk == !sp_seen)); // R6

  AST_ATTR_FIXED: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_is_store && req_contig && !req_nontemp)); // R6

  AST_SP_PULSE_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    sp_align_chk |-> ($past(start) && !$past(busy) && $past(base_is_sp))); // R7

endmodule

bind mvst_seq mvst_seq_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .base_is_sp   (base_is_sp),
  .busy         (busy),
  .done         (done),
  .sp_align_chk (sp_align_chk),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_addr     (req_addr),
  .req_byte     (req_byte),
  .req_tag_chk  (req_tag_chk),
  .req_is_store (req_is_store),
  .req_contig   (req_contig),
  .req_nontemp  (req_nontemp)
);

// File: tb/mvst_seq_tb_top.sv
`timescale 1ns/1ps
module mvst_seq_tb_top;
  localparam int ELEMS = 16;
  localparam int LANES = 4 * ELEMS;

  logic               clk = 1'b0;
  logic               rst;
  logic               start;
  logic [63:0]        base_addr;
  logic               base_is_sp;
  logic [3:0]         vec_off;
  logic               four_regs;
  logic [LANES-1:0]   lane_mask;
  logic [LANES*8-1:0] store_data;
  logic               busy, done, sp_align_chk;
  logic               req_valid, req_ready;
  logic [63:0]        req_addr;
  logic [7:0]         req_byte;
  logic               req_tag_chk, req_is_store, req_contig, req_nontemp;

  always #2 clk = ~clk;

  mvst_seq #(.ELEMS(ELEMS), .SP_CHK_EMPTY(1'b1)) dut_i (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .base_is_sp(base_is_sp), .vec_off(vec_off), .four_regs(four_regs),
    .lane_mask(lane_mask), .store_data(store_data), .busy(busy), .done(done),
    .sp_align_chk(sp_align_chk), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_byte(req_byte), .req_tag_chk(req_tag_chk),
    .req_is_store(req_is_store), .req_contig(req_contig), .req_nontemp(req_nontemp)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  logic [63:0] got_addr[$];
  logic [7:0]  got_byte[$];
  logic        got_tag[$];
  int          attr_bad = 0;
  int          sp_pulses = 0;
  int          done_count = 0;
  bit          rdy_mode = 1'b0;
  logic [7:0]  lfsr = 8'hA5;
  bit          stall_prev = 1'b0;
  logic [63:0] prev_addr;
  logic [7:0]  prev_byte;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor and back-pressure source, all at the falling edge.
  always @(negedge clk) begin
    if (!rst && stall_prev) begin
      chk(req_valid && req_addr == prev_addr && req_byte == prev_byte,
          "R9", "stalled request changed", req_addr, prev_addr);
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    req_ready = rdy_mode ? (lfsr[0] | lfsr[2]) : 1'b1;
    if (!rst) begin
      if (req_valid && req_ready) begin
        got_addr.push_back(req_addr);
        got_byte.push_back(req_byte);
        got_tag.push_back(req_tag_chk);
        if (!(req_is_store && req_contig && !req_nontemp)) attr_bad++;
      end
      if (sp_align_chk) sp_pulses++;
      if (done) done_count++;
    end
    stall_prev = !rst && req_valid && !req_ready;
    prev_addr  = req_addr;
    prev_byte  = req_byte;
  end

  task automatic run_op(input string tag, input logic [63:0] base, input bit sp,
                        input logic [3:0] off, input bit four,
                        input logic [LANES-1:0] mask, input logic [LANES*8-1:0] data,
                        input bit stalls, input bit poke, input int exp_sp);
    int nregs, walked, c0, guard, k;
    logic [63:0] first;
    got_addr.delete(); got_byte.delete(); got_tag.delete();
    attr_bad = 0; sp_pulses = 0; done_count = 0;
    rdy_mode = stalls;
    nregs  = four ? 4 : 2;
    walked = nregs * ELEMS;
    first  = base + ({{60{off[3]}}, off} * 64'(walked));
    @(negedge clk);
    base_addr = base; base_is_sp = sp; vec_off = off; four_regs = four;
    lane_mask = mask; store_data = data; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c0 = cyc;
    chk(busy, "R10", {tag, " busy after accept"}, 64'(busy), 64'd1);
    if (poke) begin
      repeat (5) @(negedge clk);
      base_addr = ~base; vec_off = off + 4'd1; lane_mask = ~mask; store_data = ~data;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 5000, "R10", {tag, " done seen"}, 64'(guard), 64'd0);
    if (!stalls && !poke)
      chk(cyc - c0 == walked + 1, "R10", {tag, " start-to-done cycles"},
          64'(cyc - c0), 64'(walked + 1));
    @(negedge clk);
    rdy_mode = 1'b0;
    chk(!busy && !req_valid, "R10", {tag, " idle after done"}, 64'(busy), 64'd0);
    chk(done_count == 1, "R11", {tag, " single done"}, 64'(done_count), 64'd1);
    chk(sp_pulses == exp_sp, sp ? "R7" : "R7", {tag, " alignment pulses"},
        64'(sp_pulses), 64'(exp_sp));
    chk(attr_bad == 0, "R6", {tag, " request attributes"}, 64'(attr_bad), 64'd0);
    k = 0;
    for (int l = 0; l < walked; l++) begin
      if (mask[l]) begin
        if (k < got_addr.size()) begin
          chk(got_addr[k] == first + 64'(l), "R2", {tag, " address"}, got_addr[k], first + 64'(l));
          chk(got_byte[k] == data[8*l +: 8], "R3", {tag, " data byte"},
              64'(got_byte[k]), 64'(data[8*l +: 8]));
          chk(got_tag[k] == !sp, "R6", {tag, " tag check flag"}, 64'(got_tag[k]), 64'(!sp));
        end
        k++;
      end
    end
    chk(got_addr.size() == k, "R4", {tag, " request count"}, 64'(got_addr.size()), 64'(k));
  endtask

  function automatic logic [LANES*8-1:0] make_data(input logic [7:0] seed);
    logic [LANES*8-1:0] d;
    for (int i = 0; i < LANES; i++) d[8*i +: 8] = seed + 8'(i * 37);
    return d;
  endfunction

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; base_addr = '0; base_is_sp = 1'b0; vec_off = '0;
    four_regs = 1'b0; lane_mask = '0; store_data = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !req_valid && !sp_align_chk, "R1", "outputs after reset",
        {60'd0, busy, done, req_valid, sp_align_chk}, 64'd0);
  endtask

  task automatic t_four_plain();   // R2 R3 R4 R6 R10
    run_op("four_pos", 64'h0000_1000_0000_0200, 1'b0, 4'd3, 1'b1,
           64'h5A5A_F00F_8001_3C3C, make_data(8'h11), 1'b0, 1'b0, 0);
    run_op("four_pos_data2", 64'h0000_1000_0000_0200, 1'b0, 4'd3, 1'b1,
           64'h5A5A_F00F_8001_3C3C, make_data(8'hC3), 1'b0, 1'b0, 0);
  endtask

  task automatic t_two_stall();    // R5 R9 R2 negative offset
    run_op("two_neg_stall", 64'h0000_0000_0040_0000, 1'b0, 4'h8, 1'b0,
           64'hFFFF_FFFF_C000_0003 | 64'h8000_0000, make_data(8'h7E), 1'b1, 1'b0, 0);
  endtask

  task automatic t_sp_active();    // R7 R6
    run_op("sp_active", 64'h0000_7FFF_FFFF_F000, 1'b1, 4'hF, 1'b1,
           64'h8000_0000_0000_0001, make_data(8'h05), 1'b1, 1'b0, 1);
  endtask

  task automatic t_sp_empty();     // R8 R5: upper lanes ignored for two registers
    run_op("sp_empty_two", 64'h0000_7FFF_FFFF_E000, 1'b1, 4'd0, 1'b0,
           64'hFFFF_FFFF_0000_0000, make_data(8'h99), 1'b0, 1'b0, 1);
    run_op("sp_empty_four", 64'h0000_7FFF_FFFF_E000, 1'b1, 4'd0, 1'b1,
           64'h0, make_data(8'h42), 1'b0, 1'b0, 1);
  endtask

  task automatic t_wrap();         // R2 modulo 2^64
    run_op("wrap", 64'hFFFF_FFFF_FFFF_FFF8, 1'b0, 4'd0, 1'b0,
           64'h0000_0000_0000_FF00, make_data(8'h3A), 1'b0, 1'b0, 0);
  endtask

  task automatic t_start_busy();   // R11
    run_op("start_busy", 64'h0000_0000_0000_8000, 1'b0, 4'd1, 1'b1,
           64'hF0F0_0000_FFFF_0F0F, make_data(8'h60), 1'b0, 1'b1, 0);
  endtask

  initial begin
    req_ready = 1'b1;
    t_reset();
    t_four_plain();
    t_two_stall();
    t_sp_active();
    t_sp_empty();
    t_wrap();
    t_start_busy();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog R10: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule